// File: doc/BRIEF.md
# Reset Configuration Word Selector

This block decides the 32-bit configuration word that a device adopts after a hard reset. Three sources compete: the external data bus pins, a word held in nonvolatile storage together with a flag that says whether that storage holds anything usable, and a built-in constant of all zeros. A configuration-select input and the storage flag together pick one of them. The picked source is not taken at a single instant. It is resampled on a fixed period through a chain of two holding registers, so that only data that has stayed put long enough can reach the output.

The reset sequencer owns the timing. It drives a one-cycle capture strobe at the end of its hard reset drive window, and the block freezes the buffered word into its output on that strobe. The output then stays the same until the next strobe. While power-on reset is active, the output, the buffer and the sample timer all return to their default state. The block also raises a weak pull-down request for the data lines when the pull-down enable bit is set and hard reset and the select input are both active. An external board can then override individual bits by driving them high.

Top module: `rstcfg_word_sel`

## Requirements
- R1: When `cfg_sel` is 1, the selected source is `bus_pins`.
- R2: When `cfg_sel` is 0 and `nv_invalid` is 0, the selected source is `nv_word`.
- R3: When `cfg_sel` is 0 and `nv_invalid` is 1, the selected source is the constant 0x0000_0000.
- R4: While `por_active` is 1, `cfg_word` is 0x0000_0000 and the sample timer and both buffer stages are cleared, whatever word was captured before.
- R5: After `por_active` falls, a sample tick occurs on the 8th rising clock edge and on every 8th edge after that. On each tick, the first buffer stage takes the selected source.
- R6: On each tick, the second buffer stage takes the value the first stage held before that edge. A source held steady for 16 clock cycles is therefore in the second stage, and a change made after the last two ticks is not yet visible there.
- R7: On a rising edge where `capture_strobe` is 1, `cfg_word` takes the value of the second buffer stage from before that edge. The new value is visible in the following cycle.
- R8: Without a strobe, `cfg_word` holds its value. Changes on `bus_pins`, `nv_word`, `nv_invalid`, `cfg_sel`, `hreset_active` or `pd_enable` have no effect on it.
- R9: `pulldown_req` is 1 exactly when `pd_enable`, `hreset_active` and `cfg_sel` are all 1. It is combinational and has no clock delay.
- R10: Bit 0 of the word vectors is the most significant bit. `bus_pins[0]` and `nv_word[0]` both land in `cfg_word[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| por_active | input | 1 | Power-on reset, active high, asynchronous assert |
| hreset_active | input | 1 | Hard reset currently driven, active high |
| cfg_sel | input | 1 | Configuration select: 1 = take word from the data pins |
| pd_enable | input | 1 | Control bit allowing the weak data bus pull-down |
| capture_strobe | input | 1 | One-cycle strobe from the sequencer at the end of the reset window |
| bus_pins | input | 32 | External data bus, bit 0 = MSB |
| nv_word | input | 32 | Nonvolatile configuration value, bit 0 = MSB |
| nv_invalid | input | 1 | 1 = nonvolatile value absent (for example, erased storage) |
| cfg_word | output | 32 | Latched hard reset configuration word, bit 0 = MSB |
| pulldown_req | output | 1 | Request for weak pull-down on all data lines |

## Verification
Cycle-level properties cover the following on every cycle: the spacing of sample ticks; the one-tick advance of the second buffer stage; the frozen buffer between ticks; the default output under power-on reset; the hold of the output between strobes; its update from the buffer on a strobe; and the pull-down gating. Only the bench's scenarios can show the parts that span many cycles. These are the three-way source choice landing in the output word, the orientation of bit 0, and the phase of the ticks relative to the release of power-on reset. They also include the proof that a change made between the last tick and a strobe is missed. A reference model updated in step with the clock follows random input traffic, random strobes and random power-on resets.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

   typedef enum logic [1:0] {
      SRC_PINS    = 2'd0,
      SRC_NVSTORE = 2'd1,
      SRC_CONST   = 2'd2
   } rcw_src_e;

   function automatic rcw_src_e pick_source(input logic sel, input logic store_invalid);
      if (sel)
         return SRC_PINS;
      else if (store_invalid)
         return SRC_CONST;
      else
         return SRC_NVSTORE;
   endfunction

endpackage

// File: rtl/rcw_src_mux.sv
module rcw_src_mux
   import rcw_pkg::*;
#(
   parameter int                  WORD_W      = 32,
   parameter logic [0:WORD_W-1]   CONST_WORD  = '0
) (
   input  logic                cfg_sel,
   input  logic                nv_invalid,
   input  logic [0:WORD_W-1]   bus_pins,
   input  logic [0:WORD_W-1]   nv_word,
   output logic [0:WORD_W-1]   src_word
);

   rcw_src_e src_kind;

   always_comb begin
      src_kind = pick_source(cfg_sel, nv_invalid);
      unique case (src_kind)
         SRC_PINS:    src_word = bus_pins;
         SRC_NVSTORE: src_word = nv_word;
         default:     src_word = CONST_WORD;
      endcase
   end

endmodule

// File: rtl/rcw_sample_timer.sv
module rcw_sample_timer #(
   parameter int SAMPLE_PERIOD = 8
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   localparam int CNT_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_PERIOD - 1);

   if (SAMPLE_PERIOD < 2) begin : g_bad_period
      $error("rcw_sample_timer: SAMPLE_PERIOD must be at least 2");
   end

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);

   // R5: two ticks never fall on neighbouring edges
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R5: the phase counter restarts right after a tick
   p_phase_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> (phase_q == '0));

endmodule

// File: rtl/rcw_dbl_buffer.sv
module rcw_dbl_buffer #(
   parameter int                WORD_W     = 32,
   parameter int                STAGES     = 2,
   parameter logic [0:WORD_W-1] RESET_WORD = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [0:WORD_W-1]  din,
   output logic [0:WORD_W-1]  dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rcw_dbl_buffer: STAGES must be at least 2");
   end

   logic [0:WORD_W-1] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or posedge rst) begin
            if (rst)
               stg_q[0] <= RESET_WORD;
            else if (tick)
               stg_q[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or posedge rst) begin
            if (rst)
               stg_q[s] <= RESET_WORD;
            else if (tick)
               stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign dout = stg_q[STAGES-1];

   // R6: the last stage advances by exactly one position per tick
   p_stage_advance_r6: assert property (@(posedge clk) disable iff (rst)
      tick |=> (dout == $past(stg_q[STAGES-2])));

   // R5: the buffer is frozen between ticks
   p_stage_frozen_r5: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(dout) && $stable(stg_q[0])));

   // R5: the head stage picks up the source on a tick
   p_head_load_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> (stg_q[0] == $past(din)));

endmodule

// File: rtl/rstcfg_word_sel.sv
module rstcfg_word_sel #(
   parameter int                WORD_W        = 32,
   parameter int                SAMPLE_PERIOD = 8,
   parameter int                BUF_STAGES    = 2,
   parameter logic [0:WORD_W-1] DEFAULT_WORD  = '0
) (
   input  logic               clk,
   input  logic               por_active,
   input  logic               hreset_active,
   input  logic               cfg_sel,
   input  logic               pd_enable,
   input  logic               capture_strobe,
   input  logic [0:WORD_W-1]  bus_pins,
   input  logic [0:WORD_W-1]  nv_word,
   input  logic               nv_invalid,
   output logic [0:WORD_W-1]  cfg_word,
   output logic               pulldown_req
);

   if (WORD_W < 1) begin : g_bad_width
      $error("rstcfg_word_sel: WORD_W must be positive");
   end

   logic [0:WORD_W-1] src_word;
   logic [0:WORD_W-1] buf_word;
   logic              tick;

   rcw_src_mux #(
      .WORD_W     (WORD_W),
      .CONST_WORD (DEFAULT_WORD)
   ) u_mux (
      .cfg_sel    (cfg_sel),
      .nv_invalid (nv_invalid),
      .bus_pins   (bus_pins),
      .nv_word    (nv_word),
      .src_word   (src_word)
   );

   rcw_sample_timer #(
      .SAMPLE_PERIOD (SAMPLE_PERIOD)
   ) u_timer (
      .clk  (clk),
      .rst  (por_active),
      .tick (tick)
   );

   rcw_dbl_buffer #(
      .WORD_W     (WORD_W),
      .STAGES     (BUF_STAGES),
      .RESET_WORD (DEFAULT_WORD)
   ) u_buf (
      .clk  (clk),
      .rst  (por_active),
      .tick (tick),
      .din  (src_word),
      .dout (buf_word)
   );

   always_ff @(posedge clk or posedge por_active) begin
      if (por_active)
         cfg_word <= DEFAULT_WORD;
      else if (capture_strobe)
         cfg_word <= buf_word;
   end

   assign pulldown_req = pd_enable & hreset_active & cfg_sel;

   // R4: power-on reset forces the default word
   p_por_default_r4: assert property (@(posedge clk)
      por_active |-> (cfg_word == DEFAULT_WORD));

   // R7: a strobe loads the buffered word
   p_capture_load_r7: assert property (@(posedge clk) disable iff (por_active)
      capture_strobe |=> (cfg_word == $past(buf_word)));

   // R8: without a strobe the word is held
   p_word_hold_r8: assert property (@(posedge clk) disable iff (por_active)
      !capture_strobe |=> $stable(cfg_word));

   // R9: a pull-down request implies hard reset and select are both active
   p_pulldown_gate_r9: assert property (@(posedge clk) disable iff (por_active)
      pulldown_req |-> (hreset_active && cfg_sel && pd_enable));

endmodule

// File: tb/tb_rstcfg_word_sel.sv
module tb_rstcfg_word_sel;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          por = 1'b1;
   logic          hres = 1'b0;
   logic          sel = 1'b0;
   logic          pden = 1'b0;
   logic          strobe = 1'b0;
   logic [0:W-1]  pins = '0;
   logic [0:W-1]  nvw = '0;
   logic          nvinv = 1'b0;
   logic [0:W-1]  word;
   logic          pdreq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rstcfg_word_sel dut (
      .clk            (clk),
      .por_active     (por),
      .hreset_active  (hres),
      .cfg_sel        (sel),
      .pd_enable      (pden),
      .capture_strobe (strobe),
      .bus_pins       (pins),
      .nv_word        (nvw),
      .nv_invalid     (nvinv),
      .cfg_word       (word),
      .pulldown_req   (pdreq)
   );

   function automatic logic [0:W-1] exp_src(logic s, logic inv, logic [0:W-1] p, logic [0:W-1] n);
      if (s) return p;
      if (inv) return '0;
      return n;
   endfunction

   // reference model built from R4..R8
   int           m_cnt;
   logic [0:W-1] m_s1, m_s2, m_word;
   always @(posedge clk or posedge por) begin
      if (por) begin
         m_cnt <= 0; m_s1 <= '0; m_s2 <= '0; m_word <= '0;
      end else begin
         if (m_cnt == 7) begin
            m_cnt <= 0;
            m_s1  <= exp_src(sel, nvinv, pins, nvw);
            m_s2  <= m_s1;
         end else begin
            m_cnt <= m_cnt + 1;
         end
         if (strobe) m_word <= m_s2;
      end
   end

   task automatic check(string req, logic [0:W-1] act, logic [0:W-1] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_neg(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_strobe();
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
   endtask

   task automatic do_por();
      por = 1'b1;
      wait_neg(3);
      check("R4", word, '0);
      por = 1'b0;
   endtask

   task automatic settle_and_capture();
      wait_neg(20);
      pulse_strobe();
   endtask

   initial begin
      wait_neg(2);
      check("R4", word, '0);
      por = 1'b0;
      // R1 with a first capture so R4 can be seen clearing it
      sel = 1'b1; pins = 32'hC3A5_5A3C;
      settle_and_capture();
      check("R1", word, 32'hC3A5_5A3C);

      // R4 / R5 / R6: phase-aligned double buffer
      @(negedge clk);
      por = 1'b1;
      wait_neg(3);
      check("R4", word, '0);
      sel = 1'b1; pins = 32'h1111_2222;
      por = 1'b0;
      wait_neg(16);
      pins = 32'h7777_8888;
      wait_neg(8);
      pulse_strobe();
      check("R6", word, 32'h1111_2222);
      wait_neg(7);
      pulse_strobe();
      check("R6", word, 32'h7777_8888);

      // R5: strobe just before the first tick after release sees only reset data
      do_por();
      pins = 32'hFFFF_0000;
      wait_neg(7);
      pulse_strobe();
      check("R5", word, '0);

      // R10: bit 0 is the MSB and follows pin 0
      sel = 1'b1; pins = 32'h8000_0000;
      settle_and_capture();
      check("R10", word, 32'h8000_0000);
      check("R10", {31'd0, word[0]}, 32'd1);

      // R2: nonvolatile source
      sel = 1'b0; nvinv = 1'b0; nvw = 32'hDEAD_BEEF; pins = 32'h0F0F_0F0F;
      settle_and_capture();
      check("R2", word, 32'hDEAD_BEEF);

      // R3: invalid storage gives the zero constant
      nvinv = 1'b1;
      settle_and_capture();
      check("R3", word, 32'h0000_0000);

      // R8: no strobe, everything else moves
      nvinv = 1'b0; nvw = 32'h1234_5678;
      settle_and_capture();
      check("R2", word, 32'h1234_5678);
      for (int k = 0; k < 40; k++) begin
         sel = k[0]; nvinv = k[1]; hres = k[2]; pden = k[3];
         pins = $urandom; nvw = $urandom;
         @(negedge clk);
      end
      check("R8", word, 32'h1234_5678);

      // R9: all eight combinations, same cycle
      for (int c = 0; c < 8; c++) begin
         pden = c[0]; hres = c[1]; sel = c[2];
         #1;
         check("R9", {31'd0, pdreq}, {31'd0, (c == 7)});
         @(negedge clk);
      end

      // random traffic against the reference model (R1..R9)
      void'($urandom(32'd5150));
      for (int i = 0; i < 4000; i++) begin
         check("R7", word, m_word);
         check("R9", {31'd0, pdreq}, {31'd0, pden & hres & sel});
         if (por) begin
            check("R4", word, '0);
            if ($urandom_range(1, 0) == 1) por = 1'b0;
         end else if ($urandom_range(499, 0) == 0) begin
            por = 1'b1;
         end
         if ($urandom_range(19, 0) == 0) begin
            sel = $urandom_range(1, 0); nvinv = $urandom_range(1, 0);
            pins = $urandom; nvw = $urandom;
         end
         hres = $urandom_range(1, 0);
         pden = $urandom_range(1, 0);
         strobe = ($urandom_range(11, 0) == 0);
         @(negedge clk);
      end
      strobe = 1'b0;
      @(negedge clk);
      check("R7", word, m_word);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule